// File: doc/BRIEF.md
# Five-Strike Watchdog Timer

This block is a hardware watchdog whose reset decision is spread over five equal intervals. Software writes a timeout in microseconds. The block loads a down counter with one fifth of that timeout and decrements it once for every pulse on a selected microsecond tick line. Each time the counter runs out, the block adds one to an expiration tally and reloads the counter. On the fifth run-out it raises a latched system reset request. The first run-out can also raise an interrupt, which warns software that the watchdog has not been serviced.

Software controls the block through a small word-wide register port. It can select the tick source, enable the interrupt and set the timeout. It can start the watchdog, which also services it while it runs, and it can stop the watchdog. The live counter value, the expiration tally and the interrupt flag are all readable. A start clears the tally, so a healthy system that keeps issuing starts never reaches the fifth expiration. The reset request stays asserted until the block itself is reset.

Top module: `expiry_watchdog`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `rst_req` are low.
- R2: The reload value is the written timeout (32-bit word at 0x0C) divided by 5 and rounded down, saturated to 2^29-1. A start loads it into the counter, and the counter reads back in bits 28:0 of the word at 0x14.
- R3: While running, each tick on the selected line lowers the counter by one. A tick that finds the counter at 1 or 0 is an expiration: the counter reloads and the tally rises by one. A reload value of 0 therefore makes every tick an expiration.
- R4: The expiration tally reads in bits 14:12 of the word at 0x04, and the running flag reads in bit 0 of that word.
- R5: On the fifth expiration the tally reads 5, the counter holds the reload value and counting stops. `rst_req` goes high on that same clock edge and stays high until `rst_n` is asserted.
- R6: If bit 4 of the control word at 0x00 is set, the first expiration sets `irq`; later expirations do not set it. Writing 1 to bit 30 of the word at 0x14 clears `irq`. If that write lands on the same cycle as a first expiration, the set takes priority and `irq` stays high. With bit 4 clear, `irq` never rises.
- R7: The command word is at 0x08. Bit 0 is start: it reloads the counter, clears the tally and sets running, even if the watchdog is already running, and it leaves an asserted `rst_req` high. Bit 1 is stop: it halts counting and keeps the counter and tally unchanged. If both bits are written together, stop wins.
- R8: Bits 3:0 of the control word select which `tick_src` line drives the counter. Ticks on other lines have no effect, and a select value of NUM_SRC or above gives no ticks at all.
- R9: A start and an expiring tick in the same cycle act as the start alone: the tally stays 0 and the counter holds the reload value.
- R10: While the watchdog is stopped, ticks leave the counter and the tally unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | NUM_SRC | One-cycle microsecond tick strobes, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | First-expiration interrupt |
| rst_req | output | 1 | Latched system reset request |

## Verification
Two pairs of functions can collide in the same clock cycle. In the first, a service start can arrive on the same cycle as the tick that would expire the counter. The bench drives the command write and the tick strobe at the same edge, then confirms that the tally is still 0 and that the counter holds the reload value. In the second, a software interrupt clear can arrive on the cycle of a first expiration. The bench provokes it the same way and expects `irq` to remain high. A sweep over timeouts 0 to 14 computes the expected counter and tally after every tick by arithmetic.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned SRC_W     = 4;
    localparam int unsigned EXP_W     = 3;
    localparam int unsigned EXP_LIMIT = 5;

    // byte offsets of the register words
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_WSTAT = 4;
    localparam int unsigned OFS_CMD   = 8;
    localparam int unsigned OFS_TMO   = 12;
    localparam int unsigned OFS_TSTAT = 20;

    // bit positions inside the words
    localparam int unsigned CMD_GO_BIT     = 0;
    localparam int unsigned CMD_HALT_BIT   = 1;
    localparam int unsigned CTRL_IRQEN_BIT = 4;
    localparam int unsigned WSTAT_RUN_BIT  = 0;
    localparam int unsigned WSTAT_EXP_LSB  = 12;
    localparam int unsigned TSTAT_IRQ_BIT  = 30;
endpackage

// File: rtl/ewd_tick_sel.sv
module ewd_tick_sel
    import ewd_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SRC_W-1:0]   sel_i,
    output logic               tick_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = src_i[i] & (sel_i == SRC_W'(i));
    end

    assign tick_o = |hit;
endmodule

// File: rtl/ewd_regs.sv
module ewd_regs
    import ewd_pkg::*;
#(
    parameter int unsigned CNT_W  = 29,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SRC_W-1:0]  src_sel_o,
    output logic              irq_en_o,
    output logic [DATA_W-1:0] tmo_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              irq_clr_o
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_TMO   = ADDR_W'(OFS_TMO);
    localparam logic [ADDR_W-1:0] A_TSTAT = ADDR_W'(OFS_TSTAT);
    localparam logic [DATA_W-1:0] CNT_MAX = DATA_W'((64'd1 << CNT_W) - 64'd1);

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic              irq_en;
        logic [DATA_W-1:0] tmo;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [DATA_W-1:0] quot;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_addr == A_CTRL) begin
            regs_d.src    = wr_data[SRC_W-1:0];
            regs_d.irq_en = wr_data[CTRL_IRQEN_BIT];
        end
        if (wr_en && wr_addr == A_TMO) begin
            regs_d.tmo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        quot     = regs_q.tmo / DATA_W'(EXP_LIMIT);
        reload_o = (quot > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : quot[CNT_W-1:0];
    end

    assign start_o   = wr_en && (wr_addr == A_CMD) && wr_data[CMD_GO_BIT] && !wr_data[CMD_HALT_BIT];
    assign stop_o    = wr_en && (wr_addr == A_CMD) && wr_data[CMD_HALT_BIT];
    assign irq_clr_o = wr_en && (wr_addr == A_TSTAT) && wr_data[TSTAT_IRQ_BIT];
    assign src_sel_o = regs_q.src;
    assign irq_en_o  = regs_q.irq_en;
    assign tmo_o     = regs_q.tmo;
endmodule

// File: rtl/ewd_core.sv
module ewd_core
    import ewd_pkg::*;
#(
    parameter int unsigned CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic [EXP_W-1:0] exp_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(EXP_LIMIT - 1);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] count;
        logic [EXP_W-1:0] exp;
        logic             irq;
        logic             rst_req;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = st_q.irq & ~irq_clr_i;
        if (stop_i) begin
            st_d.running = 1'b0;
        end else if (start_i) begin
            st_d.running = 1'b1;
            st_d.count   = reload_i;
            st_d.exp     = '0;
        end else if (st_q.running && tick_i) begin
            if (st_q.count <= CNT_W'(1)) begin
                st_d.count = reload_i;
                st_d.exp   = st_q.exp + EXP_W'(1);
                if (st_q.exp == '0 && irq_en_i) st_d.irq = 1'b1;
                if (st_q.exp == EXP_LAST) begin
                    st_d.running = 1'b0;
                    st_d.rst_req = 1'b1;
                end
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running_o = st_q.running;
    assign count_o   = st_q.count;
    assign exp_o     = st_q.exp;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst_req;
endmodule

// File: rtl/expiry_watchdog.sv
module expiry_watchdog
    import ewd_pkg::*;
#(
    parameter int unsigned CNT_W   = 29,
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic               irq,
    output logic               rst_req
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_WSTAT = ADDR_W'(OFS_WSTAT);
    localparam logic [ADDR_W-1:0] A_TMO   = ADDR_W'(OFS_TMO);
    localparam logic [ADDR_W-1:0] A_TSTAT = ADDR_W'(OFS_TSTAT);

    logic [SRC_W-1:0]  src_sel;
    logic              irq_en;
    logic [DATA_W-1:0] tmo;
    logic [CNT_W-1:0]  reload;
    logic              start_cmd, stop_cmd, irq_clr, tick;
    logic              running;
    logic [CNT_W-1:0]  count;
    logic [EXP_W-1:0]  exp_cnt;

    ewd_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .src_sel_o (src_sel),
        .irq_en_o  (irq_en),
        .tmo_o     (tmo),
        .reload_o  (reload),
        .start_o   (start_cmd),
        .stop_o    (stop_cmd),
        .irq_clr_o (irq_clr)
    );

    ewd_tick_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .src_i  (tick_src),
        .sel_i  (src_sel),
        .tick_o (tick)
    );

    ewd_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .start_i   (start_cmd),
        .stop_i    (stop_cmd),
        .irq_en_i  (irq_en),
        .irq_clr_i (irq_clr),
        .reload_i  (reload),
        .running_o (running),
        .count_o   (count),
        .exp_o     (exp_cnt),
        .irq_o     (irq),
        .rst_req_o (rst_req)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[SRC_W-1:0]     = src_sel;
                rd_data[CTRL_IRQEN_BIT] = irq_en;
            end
            A_WSTAT: begin
                rd_data[WSTAT_RUN_BIT]                         = running;
                rd_data[WSTAT_EXP_LSB +: EXP_W]                = exp_cnt;
            end
            A_TMO:   rd_data = tmo;
            A_TSTAT: begin
                rd_data[CNT_W-1:0]     = count;
                rd_data[TSTAT_IRQ_BIT] = irq;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ewd_chk.sv
module ewd_chk
    import ewd_pkg::*;
#(
    parameter int unsigned CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [EXP_W-1:0] exp_cnt,
    input logic             start_cmd,
    input logic             irq,
    input logic             rst_req
);
    // R4
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_cnt <= EXP_W'(EXP_LIMIT));

    // R5
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R5
    rst_on_fifth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> (!running && exp_cnt == EXP_W'(EXP_LIMIT)));

    // R6
    irq_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (exp_cnt == EXP_W'(1)));

    // R10
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_cmd) |=> ($stable(count) && $stable(exp_cnt)));
endmodule

bind expiry_watchdog ewd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .count     (count),
    .exp_cnt   (exp_cnt),
    .start_cmd (start_cmd),
    .irq       (irq),
    .rst_req   (rst_req)
);

// File: tb/expiry_watchdog_test.sv
module expiry_watchdog_test;
    localparam int ADDR_W = 5;
    localparam logic [4:0] A_CTRL = 5'd0, A_WST = 5'd4, A_CMD = 5'd8, A_TMO = 5'd12, A_TST = 5'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    expiry_watchdog #(.CNT_W(29), .NUM_SRC(4), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d, input logic [3:0] m);
        wr_en = we; wr_addr = a; wr_data = d; tick_src = m;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; tick_src = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic get_cnt(output longint c);
        logic [31:0] d;
        rd(A_TST, d);
        c = d[28:0];
    endtask

    task automatic get_exp(output longint e, output longint r);
        logic [31:0] d;
        rd(A_WST, d);
        e = d[14:12];
        r = d[0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        longint c, e, r;
        do_reset();

        // R1 reset state
        foreach (d[i]) ;
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_WST, d);  chk("R1 wstat", d, 0);
        rd(A_TMO, d);  chk("R1 tmo", d, 0);
        rd(A_TST, d);  chk("R1 tstat", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R2 R3 R4 R5 sweep of timeouts
        for (int t = 0; t < 15; t++) begin
            int rl, p;
            rl = t / 5;
            p  = (rl == 0) ? 1 : rl;
            do_reset();
            cyc(1, A_CTRL, 32'h12, 4'b0);
            cyc(1, A_TMO, t, 4'b0);
            cyc(1, A_CMD, 32'h1, 4'b0);
            get_cnt(c); chk("R2 reload", c, rl);
            for (int k = 1; k <= 5 * p; k++) begin
                cyc(0, A_CTRL, 0, 4'b0100);
                get_exp(e, r);
                get_cnt(c);
                if (k < 5 * p) begin
                    chk("R4 tally", e, k / p);
                    chk("R3 count", c, (rl == 0) ? 0 : rl - (k % p));
                    chk("R5 no early reset", rst_req, 0);
                    chk("R6 irq after first", irq, (k >= p) ? 1 : 0);
                end else begin
                    chk("R5 tally five", e, 5);
                    chk("R5 stopped", r, 0);
                    chk("R5 count held", c, rl);
                    chk("R5 rst_req", rst_req, 1);
                end
            end
            // R10 ticks ignored when stopped
            cyc(0, A_CTRL, 0, 4'b0100);
            get_exp(e, r); get_cnt(c);
            chk("R10 tally frozen", e, 5);
            chk("R10 count frozen", c, rl);
            // R7 start does not clear reset request
            cyc(1, A_CMD, 32'h1, 4'b0);
            get_exp(e, r);
            chk("R7 restart tally", e, 0);
            chk("R7 restart running", r, 1);
            chk("R7 rst_req kept", rst_req, 1);
        end

        // R6 interrupt disabled
        do_reset();
        cyc(1, A_CTRL, 32'h0, 4'b0);
        cyc(1, A_TMO, 5, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        cyc(0, A_CTRL, 0, 4'b0001);
        get_exp(e, r);
        chk("R6 tally without irq", e, 1);
        chk("R6 irq disabled", irq, 0);

        // R6 clear and collision with first expiration
        do_reset();
        cyc(1, A_CTRL, 32'h10, 4'b0);
        cyc(1, A_TMO, 10, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        cyc(0, A_CTRL, 0, 4'b1); cyc(0, A_CTRL, 0, 4'b1);
        chk("R6 irq set", irq, 1);
        cyc(1, A_TST, 32'h4000_0000, 4'b0);
        chk("R6 irq cleared", irq, 0);
        cyc(0, A_CTRL, 0, 4'b1); cyc(0, A_CTRL, 0, 4'b1);
        get_exp(e, r);
        chk("R6 second expiry tally", e, 2);
        chk("R6 no irq on second", irq, 0);
        cyc(1, A_CMD, 1, 4'b0);
        cyc(1, A_TST, 32'h4000_0000, 4'b0);
        cyc(0, A_CTRL, 0, 4'b1);
        cyc(1, A_TST, 32'h4000_0000, 4'b1);
        chk("R6 set beats clear", irq, 1);

        // R9 start with expiring tick
        cyc(1, A_CMD, 1, 4'b0);
        cyc(0, A_CTRL, 0, 4'b1);
        cyc(1, A_CMD, 1, 4'b1);
        get_exp(e, r); get_cnt(c);
        chk("R9 tally stays zero", e, 0);
        chk("R9 count reloaded", c, 2);

        // R7 stop, both bits, ping
        do_reset();
        cyc(1, A_CTRL, 0, 4'b0);
        cyc(1, A_TMO, 15, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        cyc(0, A_CTRL, 0, 4'b1);
        cyc(1, A_CMD, 2, 4'b0);
        for (int i = 0; i < 3; i++) cyc(0, A_CTRL, 0, 4'b1);
        get_exp(e, r); get_cnt(c);
        chk("R7 stop holds count", c, 2);
        chk("R7 stop running", r, 0);
        chk("R10 stop tally", e, 0);
        cyc(1, A_CMD, 3, 4'b0);
        get_exp(e, r);
        chk("R7 stop wins", r, 0);
        cyc(1, A_CMD, 1, 4'b0);
        get_cnt(c);
        chk("R7 start reloads", c, 3);
        cyc(1, A_TMO, 5, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        for (int i = 0; i < 4; i++) cyc(0, A_CTRL, 0, 4'b1);
        get_exp(e, r);
        chk("R7 tally four", e, 4);
        cyc(1, A_CMD, 1, 4'b0);
        for (int i = 0; i < 4; i++) cyc(0, A_CTRL, 0, 4'b1);
        get_exp(e, r);
        chk("R7 ping tally", e, 4);
        chk("R7 ping avoids reset", rst_req, 0);

        // R8 source selection
        do_reset();
        cyc(1, A_CTRL, 1, 4'b0);
        cyc(1, A_TMO, 50, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        cyc(0, A_CTRL, 0, 4'b1101);
        get_cnt(c); chk("R8 other lines ignored", c, 10);
        cyc(0, A_CTRL, 0, 4'b0010);
        get_cnt(c); chk("R8 selected line", c, 9);
        cyc(1, A_CTRL, 7, 4'b0);
        cyc(0, A_CTRL, 0, 4'b1111);
        get_cnt(c); chk("R8 out of range select", c, 9);
        rd(A_CTRL, d); chk("R8 ctrl readback", d, 7);

        // R2 saturation and large value
        cyc(1, A_TMO, 32'hFFFF_FFFF, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        get_cnt(c); chk("R2 saturated", c, 536870911);
        cyc(1, A_TMO, 5000, 4'b0);
        cyc(1, A_CMD, 1, 4'b0);
        get_cnt(c); chk("R2 fifth", c, 1000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule